// File: doc/BRIEF.md
# Oversampled Full-Speed Line Receiver

This block sits behind the two full-speed USB data lines. It samples them on a clock that runs at an integer multiple of the 12 Mbit/s bit rate, one sample per clock. Each sample is sorted into one of four line states. The block counts how long each state lasts and turns those run lengths back into the NRZI-coded bit stream. Stuffed zeros are removed, and single-ended-zero periods are reported as either end of packet or bus reset.

The output is a serial bit stream with one bit per strobe, plus single-cycle markers for start of packet, end of packet, bus reset and stuffing violations. The ratio of sample rate to bit rate is set by the parameter `OVERSAMPLE`, which defaults to 4 and must be at least 2. The bit count of a run is worked out with a phase counter, so no divider or multiplier is needed.

Top module: `fs_line_rx`

## Requirements
- R1: Each sample of `{line_p, line_n}` is classified as follows: `2'b10` is J, `2'b01` is K, `2'b00` is SE0 and `2'b11` is SE1. SE1 is treated as a data state.
- R2: A data-state run of n samples (n of at least 2) that is counted yields floor((n-1)/OVERSAMPLE) one bits. Each one bit is signalled by `rx_valid`=1 with `rx_bit`=1. A one bit is issued on the sample that brings the run count to 1+k*OVERSAMPLE, where the sample that ends the run is included in the count.
- R3: A run that ends in a change from a non-SE0 state to a non-SE0 state, and that yields fewer than six ones, is followed by a zero bit (`rx_valid`=1, `rx_bit`=0). This zero is issued one clock after the results of the change.
- R4: A run that yields exactly six ones and then changes state is a stuffed zero, and no zero bit is issued for it.
- R5: A run that yields more than six ones raises `rx_stuff_err` for one cycle when the run ends, and no zero bit follows.
- R6: A state that lasts a single sample produces no bits and no strobes. It becomes the current state, and the run count restarts.
- R7: A J run that begins while no packet is in progress produces no one bits, however long it lasts.
- R8: An SE0 run of OVERSAMPLE+1 to 2*OVERSAMPLE samples pulses `rx_eop` when the run ends and closes the packet.
- R9: Any other SE0 run of at least two samples pulses `rx_bus_reset` instead and closes the packet. No bit is issued in the same cycle as either SE0 strobe.
- R10: `rx_sop` pulses together with the first bit issued after idle or after a closed packet, and with no other bit.
- R11: Driving `rst_n` low clears every output at once, without waiting for a clock. The receiver then restarts idle with J as the last state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, OVERSAMPLE times the bit rate |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released in step with `clk` |
| line_p | input | 1 | Positive data line sample |
| line_n | input | 1 | Negative data line sample |
| rx_valid | output | 1 | A recovered bit is present on `rx_bit` |
| rx_bit | output | 1 | Recovered data bit |
| rx_sop | output | 1 | First bit of a packet |
| rx_eop | output | 1 | End-of-packet SE0 seen |
| rx_bus_reset | output | 1 | SE0 of a length other than end of packet seen |
| rx_stuff_err | output | 1 | More than six consecutive ones seen |

## Verification
A line value that is present at clock edge e is registered at that edge and processed at edge e+1. Its one bits, end-of-run strobes and stuffing error therefore appear on the outputs right after edge e+1. An appended zero follows at edge e+2. The bench model advances one step on every rising edge, from the same sampled value. Each step's expected outputs are held for one extra step and compared on the falling edge after the next rising edge. Per-scenario totals of ones, zeros and strobes are then checked against values counted by hand from the run lengths.

// File: rtl/fsrx_pkg.sv
package fsrx_pkg;

  // Encoding equals {line_p, line_n}, so the classifier is a plain cast.
  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_K   = 2'b01,
    LS_J   = 2'b10,
    LS_SE1 = 2'b11
  } line_state_e;

  // Per-run tick counter width; saturates above the stuffing limit.
  localparam int unsigned RUN_TICK_W = 3;

  // Longest legal run of ones before a forced transition.
  localparam logic [RUN_TICK_W-1:0] STUFF_LIMIT = 3'd6;

endpackage

// File: rtl/fsrx_sampler.sv
module fsrx_sampler
  import fsrx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_p,
  input  logic        line_n,
  output line_state_e state_o
);

  line_state_e state_d;
  line_state_e state_q;

  // R1: classify the pair of line levels
  always_comb begin
    state_d = line_state_e'({line_p, line_n});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LS_J;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/fsrx_run_timer.sv
module fsrx_run_timer
  import fsrx_pkg::*;
#(
  parameter int unsigned OVERSAMPLE = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  line_state_e           cur_i,
  output line_state_e           last_o,
  output logic                  change_o,
  output logic                  fresh_o,
  output logic                  tick_o,
  output logic [RUN_TICK_W-1:0] ticks_o
);

  localparam int unsigned PHASE_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam logic [PHASE_W-1:0] PHASE_TOP = PHASE_W'(OVERSAMPLE - 1);
  localparam logic [RUN_TICK_W-1:0] TICK_SAT = '1;

  line_state_e           last_q,  last_d;
  logic                  fresh_q, fresh_d;
  logic [PHASE_W-1:0]    phase_q, phase_d;
  logic [RUN_TICK_W-1:0] ticks_q, ticks_d;

  logic                  change;
  logic [PHASE_W-1:0]    phase_inc;
  logic                  tick;
  logic [RUN_TICK_W-1:0] ticks_sum;

  // fresh_q: no sample of the current state counted yet (run counter at zero).
  // phase tracks (count-1) mod OVERSAMPLE; a tick marks count = 1 + k*OVERSAMPLE.
  always_comb begin
    change    = (cur_i != last_q);
    phase_inc = (phase_q == PHASE_TOP) ? '0 : phase_q + 1'b1;
    tick      = !fresh_q && (phase_inc == '0);
    ticks_sum = (tick && (ticks_q != TICK_SAT)) ? ticks_q + 1'b1 : ticks_q;
  end

  always_comb begin
    if (change) begin
      last_d  = cur_i;
      fresh_d = 1'b1;
      phase_d = '0;
      ticks_d = '0;
    end else begin
      last_d  = last_q;
      fresh_d = 1'b0;
      phase_d = fresh_q ? '0 : phase_inc;
      ticks_d = ticks_sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q  <= LS_J;
      fresh_q <= 1'b1;
      phase_q <= '0;
      ticks_q <= '0;
    end else begin
      last_q  <= last_d;
      fresh_q <= fresh_d;
      phase_q <= phase_d;
      ticks_q <= ticks_d;
    end
  end

  assign last_o   = last_q;
  assign change_o = change;
  assign fresh_o  = fresh_q;
  assign tick_o   = tick;
  assign ticks_o  = ticks_sum;

  AST_NO_TICK_AFTER_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    change_o |=> !tick_o) else $error("tick on first sample of a run"); // R2

endmodule

// File: rtl/fsrx_bit_decoder.sv
module fsrx_bit_decoder
  import fsrx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  line_state_e           cur_i,
  input  line_state_e           last_i,
  input  logic                  change_i,
  input  logic                  fresh_i,
  input  logic                  tick_i,
  input  logic [RUN_TICK_W-1:0] ticks_i,
  output logic                  valid_o,
  output logic                  bit_o,
  output logic                  sop_o,
  output logic                  eop_o,
  output logic                  bus_reset_o,
  output logic                  stuff_err_o
);

  logic in_pkt_q, in_pkt_d;
  logic pz_q, pz_d;
  logic pz_sop_q, pz_sop_d;
  logic valid_q, valid_d;
  logic bit_q, bit_d;
  logic sop_q, sop_d;
  logic eop_q, eop_d;
  logic brst_q, brst_d;
  logic err_q, err_d;

  logic                  counting;
  logic                  one_bit;
  logic                  run_end;
  logic                  se0_end;
  logic                  data_end;
  logic [RUN_TICK_W-1:0] run_ones;
  logic                  zero_due;

  always_comb begin
    // R7: an idle J run does not count as data
    counting = (last_i != LS_SE0) && (in_pkt_q || (last_i != LS_J));
    one_bit  = counting && tick_i;
    // R6: a change out of a one-sample state is not a run end
    run_end  = change_i && !fresh_i;
    se0_end  = run_end && (last_i == LS_SE0);
    data_end = run_end && (last_i != LS_SE0);
    run_ones = counting ? ticks_i : '0;
    // R3/R4: zero only after fewer than six ones and not into SE0
    zero_due = data_end && (cur_i != LS_SE0) && (run_ones < STUFF_LIMIT);
  end

  always_comb begin
    valid_d  = one_bit || pz_q;
    bit_d    = one_bit;
    sop_d    = (one_bit && !in_pkt_q) || (pz_q && pz_sop_q);
    eop_d    = se0_end && (ticks_i == RUN_TICK_W'(1));
    brst_d   = se0_end && (ticks_i != RUN_TICK_W'(1));
    err_d    = data_end && (run_ones > STUFF_LIMIT);
    pz_d     = zero_due;
    pz_sop_d = zero_due && !in_pkt_q && !one_bit;
    in_pkt_d = se0_end ? 1'b0 : (in_pkt_q || one_bit || zero_due);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt_q <= 1'b0;
      pz_q     <= 1'b0;
      pz_sop_q <= 1'b0;
      valid_q  <= 1'b0;
      bit_q    <= 1'b0;
      sop_q    <= 1'b0;
      eop_q    <= 1'b0;
      brst_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      in_pkt_q <= in_pkt_d;
      pz_q     <= pz_d;
      pz_sop_q <= pz_sop_d;
      valid_q  <= valid_d;
      bit_q    <= bit_d;
      sop_q    <= sop_d;
      eop_q    <= eop_d;
      brst_q   <= brst_d;
      err_q    <= err_d;
    end
  end

  assign valid_o     = valid_q;
  assign bit_o       = bit_q;
  assign sop_o       = sop_q;
  assign eop_o       = eop_q;
  assign bus_reset_o = brst_q;
  assign stuff_err_o = err_q;

  AST_ZERO_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    pz_q |=> !pz_q) else $error("appended zero held two cycles"); // R3
  AST_ERR_NO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !pz_q) else $error("zero scheduled after stuffing error"); // R5
  AST_SE0_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(eop_q && brst_q)) else $error("end of packet and bus reset together"); // R8
  AST_GLITCH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (change_i && fresh_i) |=> !(eop_q || brst_q || err_q)) else $error("strobe after glitch"); // R6

endmodule

// File: rtl/fs_line_rx.sv
module fs_line_rx
  import fsrx_pkg::*;
#(
  parameter int unsigned OVERSAMPLE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_p,
  input  logic line_n,
  output logic rx_valid,
  output logic rx_bit,
  output logic rx_sop,
  output logic rx_eop,
  output logic rx_bus_reset,
  output logic rx_stuff_err
);

  line_state_e           cur_state;
  line_state_e           last_state;
  logic                  run_change;
  logic                  run_fresh;
  logic                  run_tick;
  logic [RUN_TICK_W-1:0] run_ticks;

  fsrx_sampler u_sampler (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_p  (line_p),
    .line_n  (line_n),
    .state_o (cur_state)
  );

  fsrx_run_timer #(
    .OVERSAMPLE (OVERSAMPLE)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur_i    (cur_state),
    .last_o   (last_state),
    .change_o (run_change),
    .fresh_o  (run_fresh),
    .tick_o   (run_tick),
    .ticks_o  (run_ticks)
  );

  fsrx_bit_decoder u_decoder (
    .clk         (clk),
    .rst_n       (rst_n),
    .cur_i       (cur_state),
    .last_i      (last_state),
    .change_i    (run_change),
    .fresh_i     (run_fresh),
    .tick_i      (run_tick),
    .ticks_i     (run_ticks),
    .valid_o     (rx_valid),
    .bit_o       (rx_bit),
    .sop_o       (rx_sop),
    .eop_o       (rx_eop),
    .bus_reset_o (rx_bus_reset),
    .stuff_err_o (rx_stuff_err)
  );

  AST_SOP_HAS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_sop |-> rx_valid) else $error("start marker without bit"); // R10
  AST_SOP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_sop |=> !rx_sop) else $error("start marker on consecutive bits"); // R10
  AST_SE0_END_NO_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_eop || rx_bus_reset) |-> !rx_valid) else $error("bit with SE0 strobe"); // R9

endmodule

// File: tb/fs_line_rx_test.sv
module fs_line_rx_test;

  localparam int CLK_PERIOD = 10;
  localparam int OS = 4;
  localparam logic [1:0] S_SE0 = 2'b00;
  localparam logic [1:0] S_K   = 2'b01;
  localparam logic [1:0] S_J   = 2'b10;
  localparam logic [1:0] S_SE1 = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_p = 1'b1;
  logic line_n = 1'b0;
  logic rx_valid, rx_bit, rx_sop, rx_eop, rx_bus_reset, rx_stuff_err;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fs_line_rx #(.OVERSAMPLE(OS)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_p       (line_p),
    .line_n       (line_n),
    .rx_valid     (rx_valid),
    .rx_bit       (rx_bit),
    .rx_sop       (rx_sop),
    .rx_eop       (rx_eop),
    .rx_bus_reset (rx_bus_reset),
    .rx_stuff_err (rx_stuff_err)
  );

  int checks = 0;
  int fails = 0;

  // Behavioural model: integer sample count per run, direct division.
  int         m_cnt;
  logic [1:0] m_last;
  bit         m_inpkt, m_pz, m_pzs;
  // bit order: valid, bit, sop, eop, bus_reset, stuff_err
  logic [5:0] exp_cur = '0;
  logic [5:0] exp_prev = '0;

  always @(posedge clk) begin : model
    logic [1:0] s;
    logic [5:0] e;
    bit         cntg;
    int         b;
    exp_prev = exp_cur;
    if (!rst_n) begin
      m_cnt = 0; m_last = S_J; m_inpkt = 0; m_pz = 0; m_pzs = 0;
      exp_cur = '0; exp_prev = '0;
    end else begin
      s = {line_p, line_n};
      e = '0;
      if (m_pz) begin
        e[5] = 1'b1; e[3] = m_pzs; m_pz = 0;
      end
      m_cnt = m_cnt + 1;
      cntg = (m_last != S_SE0) && (m_inpkt || m_last != S_J);
      if (s == m_last) begin
        if (cntg && m_cnt > 1 && ((m_cnt - 1) % OS) == 0) begin
          e[5] = 1'b1; e[4] = 1'b1; e[3] = !m_inpkt; m_inpkt = 1;
        end
      end else if (m_cnt == 1) begin
        m_last = s; m_cnt = 0;
      end else begin
        if (m_last == S_SE0) begin
          b = (m_cnt - 1) / OS;
          if (b == 1) e[2] = 1'b1; else e[1] = 1'b1;
          m_inpkt = 0;
        end else begin
          b = cntg ? (m_cnt - 1) / OS : 0;
          if (cntg && ((m_cnt - 1) % OS) == 0) begin
            e[5] = 1'b1; e[4] = 1'b1; e[3] = !m_inpkt; m_inpkt = 1;
          end
          if (b < 6 && s != S_SE0) begin
            m_pz = 1; m_pzs = !m_inpkt; m_inpkt = 1;
          end else if (b > 6) begin
            e[0] = 1'b1;
          end
        end
        m_last = s; m_cnt = 0;
      end
      exp_cur = e;
    end
  end

  function automatic string req_of(input logic [5:0] d);
    if (d[5] || d[4]) return "R2";
    if (d[3]) return "R10";
    if (d[2]) return "R8";
    if (d[1]) return "R9";
    return "R5";
  endfunction

  int n_ones, n_zeros, n_sop, n_eop, n_rst, n_err;

  always @(negedge clk) begin : compare
    logic [5:0] act;
    if (rst_n) begin
      act = {rx_valid, rx_bit, rx_sop, rx_eop, rx_bus_reset, rx_stuff_err};
      checks++;
      if (act !== exp_prev) begin
        fails++;
        $display("FAIL %s cycle compare act=%b exp=%b at %0t", req_of(act ^ exp_prev), act, exp_prev, $time);
      end
      if (rx_valid && rx_bit) n_ones++;
      if (rx_valid && !rx_bit) n_zeros++;
      if (rx_sop) n_sop++;
      if (rx_eop) n_eop++;
      if (rx_bus_reset) n_rst++;
      if (rx_stuff_err) n_err++;
    end
  end

  task automatic check_eq(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] s, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      {line_p, line_n} = s;
    end
  endtask

  task automatic clear_counts();
    n_ones = 0; n_zeros = 0; n_sop = 0; n_eop = 0; n_rst = 0; n_err = 0;
  endtask

  task automatic expect_counts(input string tag, input int ones, input int zeros,
                               input int sops, input int eops, input int rsts, input int errs);
    check_eq(tag, "ones", n_ones, ones);
    check_eq(tag, "zeros", n_zeros, zeros);
    check_eq(tag, "sop", n_sop, sops);
    check_eq(tag, "eop", n_eop, eops);
    check_eq(tag, "bus_reset", n_rst, rsts);
    check_eq(tag, "stuff_err", n_err, errs);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    clear_counts();
    repeat (4) @(negedge clk);
    // R11: reset state
    check_eq("R11", "outputs in reset",
             int'({rx_valid, rx_bit, rx_sop, rx_eop, rx_bus_reset, rx_stuff_err}), 0);
    rst_n = 1'b1;
    drive(S_J, 20);

    // R7: long idle J then one-bit K into end of packet
    clear_counts();
    drive(S_J, 60); drive(S_K, 4); drive(S_SE0, 8); drive(S_J, 8);
    expect_counts("R7", 0, 1, 1, 1, 0, 0);

    // R2 R3 R5 R10: mixed runs, six-one run and a seven-one run
    clear_counts();
    drive(S_K, 4); drive(S_J, 8); drive(S_K, 12); drive(S_J, 28);
    drive(S_K, 29); drive(S_SE0, 8); drive(S_J, 8);
    expect_counts("R2", 16, 4, 1, 1, 0, 1);

    // R4: exactly six ones, stuffed zero removed
    clear_counts();
    drive(S_K, 4); drive(S_J, 28); drive(S_K, 4); drive(S_SE0, 8); drive(S_J, 8);
    expect_counts("R4", 6, 2, 1, 1, 0, 0);

    // R3: five ones, zero still appended
    clear_counts();
    drive(S_K, 4); drive(S_J, 24); drive(S_K, 4); drive(S_SE0, 8); drive(S_J, 8);
    expect_counts("R3", 5, 3, 1, 1, 0, 0);

    // R6: one-sample J inside a K stretch
    clear_counts();
    drive(S_K, 8); drive(S_J, 1); drive(S_K, 7); drive(S_SE0, 8); drive(S_J, 8);
    expect_counts("R6", 2, 2, 1, 1, 0, 0);

    // R1: SE1 acts as a data state
    clear_counts();
    drive(S_K, 4); drive(S_SE1, 8); drive(S_K, 4); drive(S_SE0, 8); drive(S_J, 8);
    expect_counts("R1", 1, 3, 1, 1, 0, 0);

    // R9: long SE0
    clear_counts();
    drive(S_K, 4); drive(S_SE0, 40); drive(S_J, 8);
    expect_counts("R9", 0, 1, 1, 0, 1, 0);

    // R8: shortest end-of-packet SE0 (OS+1 samples)
    clear_counts();
    drive(S_K, 4); drive(S_SE0, OS + 1); drive(S_J, 8);
    expect_counts("R8", 0, 1, 1, 1, 0, 0);

    // R9: SE0 one sample past the end-of-packet window
    clear_counts();
    drive(S_K, 4); drive(S_SE0, 2 * OS + 1); drive(S_J, 8);
    expect_counts("R9", 0, 1, 1, 0, 1, 0);

    // R9: SE0 shorter than the end-of-packet window
    clear_counts();
    drive(S_K, 4); drive(S_SE0, OS); drive(S_J, 8);
    expect_counts("R9", 0, 1, 1, 0, 1, 0);

    // R11: asynchronous reset while a bit is on the outputs
    for (int i = 0; i < 10 && !rx_valid; i++) drive(S_K, 1);
    check_eq("R11", "valid before reset", int'(rx_valid), 1);
    #1 rst_n = 1'b0;
    #1 check_eq("R11", "outputs after async reset",
                int'({rx_valid, rx_bit, rx_sop, rx_eop, rx_bus_reset, rx_stuff_err}), 0);
    drive(S_J, 2);
    rst_n = 1'b1;
    clear_counts();
    drive(S_J, 30);
    expect_counts("R11", 0, 0, 0, 0, 0, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule